// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the eight-bit arithmetic and logic stage of an accumulator-style processor core. On each cycle that `in_valid` is high it takes the accumulator, a second operand, the current condition-flag byte and a four-bit operation code. One clock later it presents the result, a write-enable for the destination and a new flag byte. It covers addition and subtraction with and without the incoming carry, compare, the three bitwise operations, and increment and decrement of the operand. Operand selection, register files and decimal correction belong to the surrounding datapath.

The flag byte keeps fixed bit positions, because the branch and condition logic beside the block decodes them: sign in bit 7, zero in bit 6, half-carry in bit 4, parity/overflow in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 are written as zero by every defined operation. Compare updates the flags and leaves the destination untouched. Increment and decrement change every flag except carry. Operation codes 10 to 15 are reserved. They write nothing and return the incoming flag byte unchanged, so a decoder can safely issue them as bubbles.

Top module: `acc_alu`

## Requirements
- R1: Timing. A cycle with `in_valid` high raises `out_valid` on the next clock edge. A cycle with `in_valid` low gives `out_valid` and `res_we` low on the next edge, and `res` and `flags_out` keep their values. `res_we` is never high unless `out_valid` is high.
- R2: After an asynchronous reset (`rst_n` low), `out_valid`, `res_we`, `res` and `flags_out` are all zero.
- R3: Codes 0 (add) and 1 (add with carry) write `acc + opnd`, plus flag bit 0 for code 1. Carry is bit 8 of the nine-bit sum, N is cleared, and `res_we` is set.
- R4: Codes 2 (subtract) and 3 (subtract with borrow) write `acc - opnd`, minus flag bit 0 for code 3. Carry is the borrow out of the top bit, N is set, and `res_we` is set.
- R5: For codes 0 to 3 and 7, half-carry is bit 4 of `acc ^ opnd ^ result`. This is the carry into, or the borrow from, bit 4.
- R6: For codes 0, 1, 2, 3 and 7, parity/overflow is the signed overflow flag. On add it is set when both operands share a sign and the result's sign differs. On subtract it is set when the operands' signs differ and the result's sign differs from the accumulator's.
- R7: Code 7 (compare) produces exactly the flags of code 2 with `res_we` low.
- R8: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and clear carry and N. Half-carry is set for AND and clear for XOR and OR. Parity/overflow is set when the result has an even number of ones.
- R9: Code 8 (increment) writes `opnd + 1` and keeps carry from `flags_in`. It clears N, sets overflow when the result is 0x80, and sets half-carry when the result's low nibble is zero.
- R10: Code 9 (decrement) writes `opnd - 1` and keeps carry from `flags_in`. It sets N, sets overflow when `opnd` is 0x80, and sets half-carry when the low nibble of `opnd` is zero.
- R11: For codes 0 to 9, sign is bit 7 of the result and zero is set when the result is 0. Bits 5 and 3 are cleared.
- R12: Codes 10 to 15 give `res_we` low, and `flags_out` equals `flags_in` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand, or target of increment/decrement |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result and flags updated this cycle |
| res | output | 8 | Operation result |
| res_we | output | 1 | Destination write-enable |
| flags_out | output | 8 | New flag byte |

## Verification
The block keeps no state beyond its output register, so a wrong internal value appears in `res` or `flags_out` in the very cycle after the faulty operation. A wrong carry or borrow inversion inside the shared adder shows first in the carry and half-carry bits on subtraction. A wrong sign term shows only in the overflow bit, and only at operand pairs that cross the signed boundary. For that reason, directed cases at 0x7F/0x80 and at nibble edges sit beside the random mix. A write-enable or hold error shows in the compare and reserved-code cycles and in the idle cycle that follows an operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int FLAG_W = 8;

   // flag bit positions decoded by neighbouring condition logic
   localparam int FB_C  = 0;
   localparam int FB_N  = 1;
   localparam int FB_PV = 2;
   localparam int FB_H  = 4;
   localparam int FB_Z  = 6;
   localparam int FB_S  = 7;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_XOR = 4'd5,
      OP_OR  = 4'd6,
      OP_CMP = 4'd7,
      OP_INC = 4'd8,
      OP_DEC = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_XOR = 2'd1,
      LG_OR  = 2'd2
   } logic_kind_e;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HC_BIT = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] res_o,
   output logic [FLAG_W-1:0] flg_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic              c_eff;
   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] mix;

   // subtraction as a + ~b + ~cin; the carry out becomes the inverse borrow
   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      c_eff = sub_i ? ~cin_i : cin_i;
      sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
      res_o = sum[DATA_W-1:0];
      mix   = a_i ^ b_i ^ res_o;
   end

   always_comb begin
      flg_o        = '0;
      flg_o[FB_C]  = sum[DATA_W] ^ sub_i;
      flg_o[FB_N]  = sub_i;
      flg_o[FB_H]  = mix[HC_BIT];
      // same-sign test against the effective addend covers both directions
      flg_o[FB_PV] = (a_i[MSB] == b_eff[MSB]) && (res_o[MSB] != a_i[MSB]);
      flg_o[FB_Z]  = (res_o == '0);
      flg_o[FB_S]  = res_o[MSB];
   end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic_kind_e       kind_i,
   output logic [DATA_W-1:0] res_o,
   output logic [FLAG_W-1:0] flg_o
);
   always_comb begin
      case (kind_i)
         LG_AND:  res_o = a_i & b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         LG_OR:   res_o = a_i | b_i;
         default: res_o = a_i & b_i;
      endcase
   end

   always_comb begin
      flg_o        = '0;
      flg_o[FB_H]  = (kind_i == LG_AND);
      flg_o[FB_PV] = ~^res_o;
      flg_o[FB_Z]  = (res_o == '0);
      flg_o[FB_S]  = res_o[DATA_W-1];
   end

endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HC_BIT = 4
) (
   input  logic [DATA_W-1:0] v_i,
   input  logic              dec_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic [FLAG_W-1:0] flg_o
);
   localparam logic [DATA_W-1:0] SIGN_EDGE = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [HC_BIT-1:0] nib;

   always_comb begin
      res_o = dec_i ? (v_i - ONE) : (v_i + ONE);
      // increment looks at the new value, decrement at the old one
      nib   = dec_i ? v_i[HC_BIT-1:0] : res_o[HC_BIT-1:0];
   end

   always_comb begin
      flg_o        = '0;
      flg_o[FB_C]  = cy_i;
      flg_o[FB_N]  = dec_i;
      flg_o[FB_H]  = (nib == '0);
      flg_o[FB_PV] = dec_i ? (v_i == SIGN_EDGE) : (res_o == SIGN_EDGE);
      flg_o[FB_Z]  = (res_o == '0);
      flg_o[FB_S]  = res_o[DATA_W-1];
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int HC_BIT  = 4,
   parameter int OP_W    = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] res,
   output logic              res_we,
   output logic [FLAG_W-1:0] flags_out
);
   localparam int NUM_OPS = 10;

   if (DATA_W < 2)            begin : g_bad_w  $error("DATA_W must be at least 2");              end
   if (HC_BIT >= DATA_W)      begin : g_bad_hc $error("HC_BIT must lie inside the data word");   end
   if (HC_BIT < 1)            begin : g_bad_hl $error("HC_BIT must be at least 1");              end
   if ((1 << OP_W) < NUM_OPS) begin : g_bad_op $error("OP_W too narrow for the operation set");  end

   alu_op_e           op_e;
   logic              known;
   logic              use_cy;
   logic              is_sub;
   logic_kind_e       lkind;
   logic [DATA_W-1:0] ar_res, lg_res, st_res;
   logic [FLAG_W-1:0] ar_flg, lg_flg, st_flg;
   logic [DATA_W-1:0] nx_res;
   logic [FLAG_W-1:0] nx_flg;
   logic              nx_we;

   always_comb begin
      known  = (op < OP_W'(NUM_OPS));
      op_e   = alu_op_e'(op[3:0]);
      use_cy = (op_e == OP_ADC) || (op_e == OP_SBC);
      is_sub = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CMP);
      case (op_e)
         OP_XOR:  lkind = LG_XOR;
         OP_OR:   lkind = LG_OR;
         default: lkind = LG_AND;
      endcase
   end

   acc_alu_arith #(.DATA_W(DATA_W), .HC_BIT(HC_BIT)) u_arith (
      .a_i   (acc),
      .b_i   (opnd),
      .cin_i (use_cy & flags_in[FB_C]),
      .sub_i (is_sub),
      .res_o (ar_res),
      .flg_o (ar_flg)
   );

   acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i    (acc),
      .b_i    (opnd),
      .kind_i (lkind),
      .res_o  (lg_res),
      .flg_o  (lg_flg)
   );

   acc_alu_step #(.DATA_W(DATA_W), .HC_BIT(HC_BIT)) u_step (
      .v_i   (opnd),
      .dec_i (op_e == OP_DEC),
      .cy_i  (flags_in[FB_C]),
      .res_o (st_res),
      .flg_o (st_flg)
   );

   always_comb begin
      nx_res = acc;
      nx_flg = flags_in;
      nx_we  = 1'b0;
      if (known) begin
         case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
               nx_res = ar_res; nx_flg = ar_flg; nx_we = 1'b1;
            end
            OP_CMP: begin
               nx_res = acc;    nx_flg = ar_flg; nx_we = 1'b0;
            end
            OP_AND, OP_XOR, OP_OR: begin
               nx_res = lg_res; nx_flg = lg_flg; nx_we = 1'b1;
            end
            OP_INC, OP_DEC: begin
               nx_res = st_res; nx_flg = st_flg; nx_we = 1'b1;
            end
            default: begin
               nx_res = acc;    nx_flg = flags_in; nx_we = 1'b0;
            end
         endcase
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            res_we    <= 1'b0;
            res       <= '0;
            flags_out <= '0;
         end else begin
            out_valid <= in_valid;
            res_we    <= in_valid & nx_we;
            if (in_valid) begin
               res       <= nx_res;
               flags_out <= nx_flg;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign res_we    = in_valid & nx_we;
      assign res       = nx_res;
      assign flags_out = nx_flg;
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OP_W    = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   op,
   input logic [FLAG_W-1:0] flags_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] res,
   input logic              res_we,
   input logic [FLAG_W-1:0] flags_out
);
   if (REG_OUT) begin : g_seq
      assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && !res_we && $stable(res) && $stable(flags_out)));

      assert_we_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
         res_we |-> out_valid);

      assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_W'(7)) |=> (!res_we && flags_out[FB_N]));

      assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op >= OP_W'(4) && op <= OP_W'(6)) |=> (res_we && !flags_out[FB_C] && !flags_out[FB_N]));

      assert_inc_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_W'(8)) |=> (flags_out[FB_C] == $past(flags_in[FB_C]) && !flags_out[FB_N]));

      assert_dec_keeps_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_W'(9)) |=> (flags_out[FB_C] == $past(flags_in[FB_C]) && flags_out[FB_N]));

      assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
         res_we |-> (flags_out[FB_Z] == (res == '0) && flags_out[FB_S] == res[DATA_W-1]));

      assert_pad_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
         res_we |-> (!flags_out[5] && !flags_out[3]));

      assert_reserved_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op >= OP_W'(10)) |=> (!res_we && flags_out == $past(flags_in)));
   end

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .flags_in  (flags_in),
   .out_valid (out_valid),
   .res       (res),
   .res_we    (res_we),
   .flags_out (flags_out)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] acc = '0, opnd = '0, flags_in = '0;
   logic       out_valid, res_we;
   logic [7:0] res, flags_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
      .opnd(opnd), .flags_in(flags_in), .out_valid(out_valid), .res(res),
      .res_we(res_we), .flags_out(flags_out)
   );

   // expected {we, result, flags}, from integer and signed arithmetic
   function automatic logic [16:0] model(input int o, input int a, input int b, input int f);
      int cy, r, fl, we, sa, sb, sv, t, ones;
      cy = f & 1; fl = 0; we = 1; r = 0;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      case (o)
         0, 1: begin
            t = (o == 1) ? cy : 0;
            r = a + b + t;
            if (r > 255) fl |= 1;
            if ((a % 16) + (b % 16) + t > 15) fl |= 16;
            sv = sa + sb + t;
            if (sv > 127 || sv < -128) fl |= 4;
            r = r % 256;
         end
         2, 3, 7: begin
            t = (o == 3) ? cy : 0;
            r = a - b - t;
            if (r < 0) begin fl |= 1; r += 256; end
            if ((a % 16) - (b % 16) - t < 0) fl |= 16;
            sv = sa - sb - t;
            if (sv > 127 || sv < -128) fl |= 4;
            fl |= 2;
            if (o == 7) we = 0;
         end
         4, 5, 6: begin
            r = (o == 4) ? (a & b) : (o == 5) ? (a ^ b) : (a | b);
            ones = 0;
            for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
            if (ones % 2 == 0) fl |= 4;
            if (o == 4) fl |= 16;
         end
         8: begin
            r = (b + 1) % 256;
            fl |= cy;
            if (b == 127) fl |= 4;
            if ((b % 16) == 15) fl |= 16;
         end
         9: begin
            r = (b + 255) % 256;
            fl |= cy | 2;
            if (b == 128) fl |= 4;
            if ((b % 16) == 0) fl |= 16;
         end
         default: begin
            we = 0; fl = f; r = -1;
         end
      endcase
      if (o <= 9) begin
         if (r >= 128) fl |= 128;
         if (r == 0) fl |= 64;
      end
      return {we[0], r[7:0], fl[7:0]};
   endfunction

   function automatic string req_of(input int o);
      case (o)
         0, 1:    return "R3";
         2, 3:    return "R4";
         4, 5, 6: return "R8";
         7:       return "R7";
         8:       return "R9";
         9:       return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic run_op(input int o, input int a, input int b, input int f, input string tag);
      logic [16:0] e;
      bit bad;
      e = model(o, a, b, f);
      @(negedge clk);
      op = 4'(o); acc = 8'(a); opnd = 8'(b); flags_in = 8'(f); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      n_run++;
      bad = !out_valid || (res_we !== e[16]) || (flags_out !== e[7:0]) || (e[16] && res !== e[15:8]);
      if (bad) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: valid=%b we=%b res=%02h flags=%02h expected we=%b res=%02h flags=%02h",
                  tag, o, a, b, f, out_valid, res_we, res, flags_out, e[16], e[15:8], e[7:0]);
      end
   endtask

   task automatic idle_check();
      logic [7:0] r0, f0;
      @(negedge clk);
      r0 = res; f0 = flags_out;
      in_valid = 1'b0; op = 4'd0; acc = 8'hFF; opnd = 8'h01; flags_in = 8'hFF;
      @(negedge clk);
      n_run++;
      if (out_valid || res_we || res !== r0 || flags_out !== f0) begin
         n_fail++;
         $display("FAIL R1 idle: valid=%b we=%b res=%02h flags=%02h expected valid=0 we=0 res=%02h flags=%02h",
                  out_valid, res_we, res, flags_out, r0, f0);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      n_run++;
      if (out_valid || res_we || res !== 8'h00 || flags_out !== 8'h00) begin
         n_fail++;
         $display("FAIL R2 reset: valid=%b we=%b res=%02h flags=%02h expected all zero",
                  out_valid, res_we, res, flags_out);
      end
      rst_n = 1'b1;

      run_op(0, 8'h0F, 8'h01, 0, "R5");     // half-carry out of low nibble
      run_op(2, 8'h10, 8'h01, 0, "R5");     // half-borrow
      run_op(0, 8'h7F, 8'h01, 0, "R6");     // positive overflow
      run_op(2, 8'h80, 8'h01, 0, "R6");     // negative overflow on subtract
      run_op(3, 8'h00, 8'h00, 1, "R4");     // borrow from incoming carry only
      run_op(1, 8'hFF, 8'h00, 1, "R3");     // carry from incoming carry only
      run_op(0, 8'h80, 8'h80, 0, "R11");    // zero result, carry, overflow
      run_op(7, 8'h42, 8'h42, 0, "R7");     // equal compare
      run_op(4, 8'hF0, 8'h0F, 0, "R8");
      run_op(5, 8'h03, 8'h01, 1, "R8");
      run_op(8, 8'h00, 8'h7F, 1, "R9");
      run_op(8, 8'h00, 8'hFF, 0, "R9");
      run_op(9, 8'h00, 8'h80, 1, "R10");
      run_op(9, 8'h00, 8'h01, 0, "R10");
      run_op(12, 8'h55, 8'hAA, 8'hA5, "R12");
      idle_check();
      run_op(15, 8'h00, 8'h00, 8'h28, "R12");
      idle_check();

      for (int i = 0; i < 30000; i++) begin
         int o;
         o = int'($urandom % 16);
         run_op(o, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), req_of(o));
         if (i % 1000 == 999) idle_check();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule